// File: doc/BRIEF.md
# Display Controller Host Bus Front End

This block sits between a host processor's parallel bus and the internals of a display driver. It understands two parallel bus styles: one with separate active-low write and read strobes, and one with a read/write direction line qualified by an active-high enable. Either style can be 16 bits wide or 8 bits wide. A register-select line, together with the transfer direction, picks one of four operations: load the index, read status, write data, or read display memory.

The block keeps a 16-bit index, a 16-bit write word and a 16-bit read word. A completed data write goes straight to the indexed control register or, when the index selects display memory, to the display RAM at an auto-incrementing address. The host never waits for this. Display memory reads are pipelined: each read hands back the word already held in the read register and then fetches the next one. As a result, the first read after the address or index changes returns a dummy value.

All strobes are brought into the internal clock through a synchronizer and acted on once, on their leading edge. In 8-bit mode a 16-bit value moves in two byte cycles on the low data lanes, high byte first.

Top module: `hbif_host_front`

## Requirements
- R1: After reset the index is 0, `bus_dout` is 0, the byte phase is 0, and no write or prefetch pulse is issued.
- R2: `bus_mode[1]`=0 selects the strobe style: `cs_n` low with `rw_wrn` low is a write and `e_rdn` low is a read. `bus_mode[1]`=1 selects the enable style: `cs_n` low with `e_rdn` high is a transfer, and `rw_wrn`=1 means read, 0 means write. In both styles `rs`=0 selects index/status and `rs`=1 selects data.
- R3: An index write loads the index (16 bits wide, or `{8'h00, byte}` in 8-bit mode). A status read returns `{8'h00, index[7:0]}`.
- R4: A completed data write while the index is not 16'h0022 gives exactly one `reg_we` pulse, with `reg_addr` = index[7:0] and `reg_wdata` = the word. At most one of `reg_we`, `ram_we` and `ram_re` is high in any cycle.
- R5: A completed data write while the index is 16'h0022 gives one `ram_we` pulse at the current address. The address then steps by one, modulo 2^AW.
- R6: A completed data write while the index is 16'h0021 sets the address counter to data[AW-1:0] and also issues a `reg_we`.
- R7: A data read while the index is 16'h0022 returns the read register. It then pulses `ram_re` at the current address and steps the address. `ram_rdata`, valid one cycle after `ram_re`, reloads the read register. The first read after an address change is therefore a dummy, and later reads return consecutive words.
- R8: With `bus_mode[0]`=1, data moves as two byte cycles on `[7:0]`, high byte first. No write is issued after the first byte. A read returns the high byte and then the low byte, and the prefetch is issued after the low byte. An index write is a single byte and clears the byte phase.
- R9: Each strobe is acted on exactly once however long it is held, and writes may follow each other with no status polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 2 | Static: bit 1 selects the bus style, bit 0 selects 8-bit mode |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 index/status, 1 data |
| rw_wrn | input | 1 | Write strobe (strobe style) or read/write line (enable style) |
| e_rdn | input | 1 | Read strobe (strobe style) or enable (enable style) |
| bus_din | input | 16 | Host write data |
| bus_dout | output | 16 | Host read data |
| reg_we | output | 1 | Control register write pulse |
| reg_addr | output | IW | Control register number |
| reg_wdata | output | 16 | Control register data |
| ram_we | output | 1 | Display RAM write pulse |
| ram_waddr | output | AW | Display RAM write address |
| ram_wdata | output | 16 | Display RAM write data |
| ram_re | output | 1 | Display RAM prefetch request |
| ram_raddr | output | AW | Display RAM read address |
| ram_rdata | input | 16 | Display RAM data, valid the cycle after `ram_re` |

## Verification
A wrong index shows up at the next status read and in the `reg_addr` of the next register write, within one host transfer. A slipped byte phase swaps or merges bytes in the next narrow word, and a write pulse appears one byte too early. A wrong address counter moves data to the wrong RAM word; it is exposed by reading back through the prefetch path, which also shows an off-by-one in the dummy-read pipeline on the second read after an address load.

// File: rtl/hbif_pkg.sv
package hbif_pkg;

  typedef enum logic [1:0] {
    OP_INDEX  = 2'd0,
    OP_STATUS = 2'd1,
    OP_WDATA  = 2'd2,
    OP_RDATA  = 2'd3
  } hb_op_e;

  // Maps transfer direction and register select onto one of four operations.
  function automatic hb_op_e op_decode(input logic is_rd, input logic rsel);
    case ({rsel, is_rd})
      2'b00:   op_decode = OP_INDEX;
      2'b01:   op_decode = OP_STATUS;
      2'b10:   op_decode = OP_WDATA;
      default: op_decode = OP_RDATA;
    endcase
  endfunction

  // Status word: the low iw bits of the index, the rest zero.
  function automatic logic [15:0] status_word(input logic [15:0] idx, input int iw);
    for (int b = 0; b < 16; b++) status_word[b] = (b < iw) ? idx[b] : 1'b0;
  endfunction

  function automatic logic [15:0] merge_bytes(input logic [7:0] hi, input logic [7:0] lo);
    merge_bytes = {hi, lo};
  endfunction

  // Byte shown on the low lanes in narrow mode: high byte first.
  function automatic logic [7:0] narrow_pick(input logic [15:0] w, input logic second);
    narrow_pick = second ? w[7:0] : w[15:8];
  endfunction

endpackage

// File: rtl/hbif_strobe_sync.sv
module hbif_strobe_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_e,
  input  logic cs_n,
  input  logic rw_wrn,
  input  logic e_rdn,
  output logic wr_evt,
  output logic rd_evt
);
  logic wr_req, rd_req;
  logic [SYNC:0] wr_sh, rd_sh;

  always_comb begin
    if (mode_e) begin
      wr_req = !cs_n && e_rdn && !rw_wrn;
      rd_req = !cs_n && e_rdn && rw_wrn;
    end else begin
      wr_req = !cs_n && !rw_wrn;
      rd_req = !cs_n && !e_rdn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh <= '0;
      rd_sh <= '0;
    end else begin
      wr_sh <= {wr_sh[SYNC-1:0], wr_req};
      rd_sh <= {rd_sh[SYNC-1:0], rd_req};
    end
  end

  assign wr_evt = wr_sh[SYNC-1] && !wr_sh[SYNC];
  assign rd_evt = rd_sh[SYNC-1] && !rd_sh[SYNC];

  AST_WR_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_evt |=> !wr_evt); // R9
  AST_RD_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_evt |=> !rd_evt); // R9

endmodule

// File: rtl/hbif_regs.sv
module hbif_regs
  import hbif_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          IW       = 8,
  parameter logic [15:0] IDX_ADDR = 16'h0021,
  parameter logic [15:0] IDX_GRAM = 16'h0022
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          narrow,
  input  logic          wr_evt,
  input  logic          rd_evt,
  input  logic          rs,
  input  logic [15:0]   din,
  output logic [15:0]   idx,
  output logic          phase,
  output logic          reg_we,
  output logic [IW-1:0] reg_addr,
  output logic [15:0]   reg_wdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [15:0]   ram_wdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr
);
  hb_op_e        op;
  logic          idx_evt, dwr_evt, drd_evt, wdone, rdone, to_gram, to_addr;
  logic [7:0]    hi_q;
  logic [15:0]   wword;
  logic [AW-1:0] addr;

  assign op      = op_decode(rd_evt, rs);
  assign idx_evt = wr_evt && (op == OP_INDEX);
  assign dwr_evt = wr_evt && (op == OP_WDATA);
  assign drd_evt = rd_evt && (op == OP_RDATA);
  assign wdone   = dwr_evt && (!narrow || phase);
  assign rdone   = drd_evt && (!narrow || phase);
  assign to_gram = (idx == IDX_GRAM);
  assign to_addr = (idx == IDX_ADDR);
  assign wword   = narrow ? merge_bytes(hi_q, din[7:0]) : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; phase <= 1'b0; hi_q <= '0; addr <= '0;
      reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      ram_we <= 1'b0; ram_waddr <= '0; ram_wdata <= '0;
      ram_re <= 1'b0; ram_raddr <= '0;
    end else begin
      reg_we <= 1'b0;
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      if (idx_evt) begin
        idx   <= narrow ? {8'h00, din[7:0]} : din;
        phase <= 1'b0;
      end else if (dwr_evt || drd_evt) begin
        phase <= narrow && !phase;
        if (dwr_evt && narrow && !phase) hi_q <= din[7:0];
      end
      if (wdone) begin
        if (to_gram) begin
          ram_we    <= 1'b1;
          ram_waddr <= addr;
          ram_wdata <= wword;
          addr      <= addr + 1'b1;
        end else begin
          reg_we    <= 1'b1;
          reg_addr  <= idx[IW-1:0];
          reg_wdata <= wword;
          if (to_addr) addr <= wword[AW-1:0];
        end
      end
      if (rdone && to_gram) begin
        ram_re    <= 1'b1;
        ram_raddr <= addr;
        addr      <= addr + 1'b1;
      end
    end
  end

  AST_ONE_TARGET:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reg_we, ram_we, ram_re})); // R4
  AST_GRAM_STEP:    assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> addr == ram_waddr + 1'b1); // R5
  AST_PREFETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n) ram_re |-> addr == ram_raddr + 1'b1); // R7
  AST_INDEX_PHASE:  assert property (@(posedge clk) disable iff (!rst_n) idx_evt |=> !phase); // R8
  AST_NARROW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                      (dwr_evt && narrow && !phase) |=> !(reg_we || ram_we)); // R8

endmodule

// File: rtl/hbif_rdpath.sv
module hbif_rdpath
  import hbif_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        narrow,
  input  logic        rd_evt,
  input  logic        rs,
  input  logic        phase,
  input  logic [15:0] idx,
  input  logic        ram_re,
  input  logic [15:0] ram_rdata,
  output logic [15:0] bus_dout
);
  logic        re_d;
  logic [15:0] rdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_d     <= 1'b0;
      rdr      <= '0;
      bus_dout <= '0;
    end else begin
      re_d <= ram_re;
      if (re_d) rdr <= ram_rdata;
      if (rd_evt) begin
        if (!rs)         bus_dout <= status_word(idx, IW);
        else if (narrow) bus_dout <= {8'h00, narrow_pick(rdr, phase)};
        else             bus_dout <= rdr;
      end
    end
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_evt |=> $stable(bus_dout)); // R3

endmodule

// File: rtl/hbif_host_front.sv
module hbif_host_front #(
  parameter int          AW       = 12,
  parameter int          IW       = 8,
  parameter int          SYNC     = 2,
  parameter logic [15:0] IDX_ADDR = 16'h0021,
  parameter logic [15:0] IDX_GRAM = 16'h0022
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_mode,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          rw_wrn,
  input  logic          e_rdn,
  input  logic [15:0]   bus_din,
  output logic [15:0]   bus_dout,
  output logic          reg_we,
  output logic [IW-1:0] reg_addr,
  output logic [15:0]   reg_wdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [15:0]   ram_wdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [15:0]   ram_rdata
);
  logic        wr_evt, rd_evt, phase;
  logic [15:0] idx;

  hbif_strobe_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .mode_e(bus_mode[1]), .cs_n(cs_n),
    .rw_wrn(rw_wrn), .e_rdn(e_rdn), .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  hbif_regs #(.AW(AW), .IW(IW), .IDX_ADDR(IDX_ADDR), .IDX_GRAM(IDX_GRAM)) u_regs (
    .clk(clk), .rst_n(rst_n), .narrow(bus_mode[0]), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .rs(rs), .din(bus_din), .idx(idx), .phase(phase),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr)
  );

  hbif_rdpath #(.IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .narrow(bus_mode[0]), .rd_evt(rd_evt), .rs(rs),
    .phase(phase), .idx(idx), .ram_re(ram_re), .ram_rdata(ram_rdata), .bus_dout(bus_dout)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !reg_we && !ram_we && !ram_re && bus_dout == 16'h0); // R1

endmodule

// File: tb/test_hbif_host_front.sv
module test_hbif_host_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [1:0]    bus_mode = 2'b00;
  logic          cs_n = 1'b1, rs = 1'b0, rw_wrn = 1'b1, e_rdn = 1'b1;
  logic [15:0]   bus_din = '0, bus_dout, reg_wdata, ram_wdata, ram_rdata = '0;
  logic [7:0]    reg_addr;
  logic          reg_we, ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr;

  int n_tests = 0, n_fail = 0;
  int reg_cnt = 0, ram_cnt = 0;
  logic [7:0]    last_ra = '0;
  logic [15:0]   last_rd = '0, last_wd = '0;
  logic [AW-1:0] last_wa = '0;
  logic [15:0]   mem [0:(1<<AW)-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbif_host_front i_hbif_host_front (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .rs(rs),
    .rw_wrn(rw_wrn), .e_rdn(e_rdn), .bus_din(bus_din), .bus_dout(bus_dout),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
  );

  // Display RAM model and write-port log.
  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_waddr] <= ram_wdata;
      ram_cnt <= ram_cnt + 1; last_wa <= ram_waddr; last_wd <= ram_wdata;
    end
    if (ram_re) ram_rdata <= mem[ram_raddr];
    if (reg_we) begin
      reg_cnt <= reg_cnt + 1; last_ra <= reg_addr; last_rd <= reg_wdata;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; rw_wrn = 1'b1; e_rdn = bus_mode[1] ? 1'b0 : 1'b1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); cs_n = 1'b1; bus_mode = m; idle_pins();
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic is_rd, input logic rsv, input logic [15:0] d,
                      input int hold, output logic [15:0] q);
    @(negedge clk);
    rs = rsv; bus_din = d; cs_n = 1'b0;
    if (bus_mode[1]) begin rw_wrn = is_rd; e_rdn = 1'b1; end
    else if (is_rd) e_rdn = 1'b0;
    else rw_wrn = 1'b0;
    repeat (hold) @(negedge clk);
    q = bus_dout;
    idle_pins();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic rsv, input logic [15:0] d);
    logic [15:0] q;
    xfer(1'b0, rsv, d, 5, q);
  endtask

  task automatic rd(input logic rsv, output logic [15:0] q);
    xfer(1'b1, rsv, 16'h0, 5, q);
  endtask

  task automatic t_reset();
    logic [15:0] q;
    check("R1 dout after reset", bus_dout, 16'h0000);
    check("R1 no writes after reset", 16'(reg_cnt + ram_cnt), 16'd0);
    rd(1'b0, q);
    check("R1 index after reset", q, 16'h0000);
  endtask

  task automatic t_index_regs();
    logic [15:0] q;
    wr(1'b0, 16'h005A); rd(1'b0, q);
    check("R3 R2 status after index write", q, 16'h005A);
    wr(1'b0, 16'h1234); rd(1'b0, q);
    check("R3 status keeps low index bits", q, 16'h0034);
    wr(1'b0, 16'h0007); wr(1'b1, 16'hBEEF);
    check("R4 one reg write", 16'(reg_cnt), 16'd1);
    check("R4 reg number", {8'h0, last_ra}, 16'h0007);
    check("R4 reg data", last_rd, 16'hBEEF);
    check("R4 no ram write", 16'(ram_cnt), 16'd0);
  endtask

  task automatic t_gram();
    logic [15:0] q;
    wr(1'b0, 16'h0021); wr(1'b1, 16'h0100);
    check("R6 address load is also a reg write", 16'(reg_cnt), 16'd2);
    wr(1'b0, 16'h0022);
    wr(1'b1, 16'h1111); wr(1'b1, 16'h2222); wr(1'b1, 16'h3333);
    check("R5 three ram writes", 16'(ram_cnt), 16'd3);
    check("R5 last ram address", 16'(last_wa), 16'h0102);
    wr(1'b0, 16'h0021); wr(1'b1, 16'h0FFF); wr(1'b0, 16'h0022);
    wr(1'b1, 16'hAAAA); wr(1'b1, 16'hBBBB);
    check("R5 address wraps", 16'(last_wa), 16'h0000);
    wr(1'b0, 16'h0021); wr(1'b1, 16'h0100); wr(1'b0, 16'h0022);
    rd(1'b1, q);
    rd(1'b1, q); check("R7 first real read", q, 16'h1111);
    rd(1'b1, q); check("R7 second read", q, 16'h2222);
    rd(1'b1, q); check("R7 third read", q, 16'h3333);
    wr(1'b0, 16'h0021); wr(1'b1, 16'h0FFF); wr(1'b0, 16'h0022);
    rd(1'b1, q);
    rd(1'b1, q); check("R7 read at top", q, 16'hAAAA);
    rd(1'b1, q); check("R7 read after wrap", q, 16'hBBBB);
  endtask

  task automatic t_enable_style();
    logic [15:0] q;
    set_mode(2'b10);
    wr(1'b0, 16'h0033); rd(1'b0, q);
    check("R2 enable style status", q, 16'h0033);
    wr(1'b0, 16'h0021); wr(1'b1, 16'h0101); wr(1'b0, 16'h0022);
    rd(1'b1, q);
    rd(1'b1, q); check("R2 enable style ram read", q, 16'h2222);
    wr(1'b1, 16'h7777);
    check("R2 enable style ram write", last_wd, 16'h7777);
  endtask

  task automatic t_narrow();
    logic [15:0] q;
    int rc, mc;
    set_mode(2'b01);
    wr(1'b0, 16'h0021);
    rc = reg_cnt;
    wr(1'b1, 16'h0002);
    check("R8 no write after high byte", 16'(reg_cnt - rc), 16'd0);
    wr(1'b1, 16'h0000);
    check("R8 write after low byte", 16'(reg_cnt - rc), 16'd1);
    wr(1'b0, 16'h0022);
    mc = ram_cnt;
    wr(1'b1, 16'h00CA);
    check("R8 no ram write after high byte", 16'(ram_cnt - mc), 16'd0);
    wr(1'b1, 16'h00FE);
    check("R8 merged word", last_wd, 16'hCAFE);
    check("R8 merged word address", 16'(last_wa), 16'h0200);
    wr(1'b1, 16'h0011); wr(1'b0, 16'h0022);
    wr(1'b1, 16'h00AB); wr(1'b1, 16'h00CD);
    check("R8 index write clears phase", last_wd, 16'hABCD);
    rd(1'b0, q); check("R8 narrow status", q, 16'h0022);
    wr(1'b0, 16'h0021); wr(1'b1, 16'h0002); wr(1'b1, 16'h0000); wr(1'b0, 16'h0022);
    rd(1'b1, q); rd(1'b1, q);
    rd(1'b1, q); check("R8 read high byte", q, 16'h00CA);
    rd(1'b1, q); check("R8 read low byte", q, 16'h00FE);
    rd(1'b1, q); check("R8 next word high", q, 16'h00AB);
    rd(1'b1, q); check("R8 next word low", q, 16'h00CD);
  endtask

  task automatic t_long_strobe();
    logic [15:0] q;
    int rc;
    set_mode(2'b00);
    wr(1'b0, 16'h0009);
    rc = reg_cnt;
    xfer(1'b0, 1'b1, 16'h4242, 30, q);
    check("R9 long strobe acts once", 16'(reg_cnt - rc), 16'd1);
    wr(1'b1, 16'h4343); wr(1'b1, 16'h4444);
    check("R9 back to back writes", 16'(reg_cnt - rc), 16'd3);
    check("R9 last back to back data", last_rd, 16'h4444);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_index_regs();
    t_gram();
    t_enable_style();
    t_narrow();
    t_long_strobe();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule